// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block holds the per-pin configuration of a bank of general-purpose I/O pins and presents it to an external pad multiplexer. Software reaches it through a small word-addressed register bus. The bus writes in the same cycle it is strobed, and reads return combinationally. For each pin the bank stores an output data latch, a direction bit, a pull-disable bit, a sleep-retention bit and two function-select bits. The data latch and the direction bit are never written directly. Separate set and clear words change them, so one pin can be updated without a read-modify-write that would race with other software.

The pad side receives, for each pin, an output enable, an output value, a pull enable, a pull polarity and a two-bit function select. The pull polarity is taken from the output data latch, so an input pin with its pull enabled pulls up when its latch is 1 and down when its latch is 0. While the chip-level sleep input is high, every pin whose retention bit is 0 becomes an input with its pull enabled. Pad input levels pass through a two-flop synchronizer and can be read back on a read-only word.

Top module: `gpio_bank`

## Requirements
- R1: After reset all latches are 0. Every pin is then a GPIO input (pin_oe 0) with its pull enabled (pin_pull_en 1) and pulled down (pin_pull_up 0), its function select is 00, and every readable word returns 0.
- R2: A write to word 2 sets the data latch of each pin whose write bit is 1. A write to word 3 clears the data latch of each pin whose write bit is 1. Pins whose write bit is 0 keep their latch. Word 1 reads the data latches back.
- R3: A write to word 5 makes each pin whose write bit is 1 an output. A write to word 6 makes each pin whose write bit is 1 an input. Word 4 reads the direction bits back, with 1 meaning output.
- R4: pin_out of each pin equals its data latch, and pin_oe equals its direction bit while sleep is not in force for that pin.
- R5: A pin's pull is enabled exactly when it is an input and its pull-disable bit (word 7) is 0. pin_pull_up equals the pin's data latch.
- R6: Words 9 (select A) and 10 (select B) are read/write and drive pin_func_a and pin_func_b. The pair (A,B) selects the function: 00 is GPIO, 10 is function A, 01 is function B and 11 is function C.
- R7: While sleep_req is 1, every pin whose retention bit (word 8) is 0 has pin_oe 0 and pin_pull_en 1 in the same cycle. Pins whose retention bit is 1 keep their configured outputs. When sleep_req falls, the configured outputs return.
- R8: Word 0 returns the pad input levels. A change on pad_in becomes visible there after the second rising clock edge.
- R9: Writes to word 0 change no latch. The write-only words 2, 3, 5 and 6, and any unmapped word, read as 0.
- R10: The pull-disable word 7 and the retention word 8 are read/write and read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sleep_req | input | 1 | Chip-level sleep indication |
| pad_in | input | 32 | Asynchronous pad input levels |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin output value |
| pin_pull_en | output | 32 | Per-pin pull resistor enable |
| pin_pull_up | output | 32 | Per-pin pull polarity, 1 means pull-up |
| pin_func_a | output | 32 | Per-pin function select bit A |
| pin_func_b | output | 32 | Per-pin function select bit B |

## Verification
Every stored bit reaches a pad output in the same cycle. A data latch, direction bit or select bit that takes the wrong value after a write therefore shows on pin_out, pin_oe, pin_pull_up or the function pins at the first sample after the write edge, before any readback. A bit that changes when its neighbour is strobed shows as an unexpected difference in the full-word comparisons. A fault in the synchronizer shows only on word 0, as a sample that arrives one edge early or late. The checks are timed to the second edge so that both of these are caught.

// File: rtl/gpio_bank_pkg.sv
// Package: shared word map for the GPIO pin control bank.
// Assumes a word-addressed bus with a 4-bit address.
package gpio_bank_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        W_PAD_LVL  = 4'd0,   // read-only synchronized pad levels
        W_DOUT     = 4'd1,   // read-only data latch readback
        W_DOUT_SET = 4'd2,   // write-one-to-set data
        W_DOUT_CLR = 4'd3,   // write-one-to-clear data
        W_DIR      = 4'd4,   // read-only direction readback
        W_DIR_SET  = 4'd5,   // write-one-to-set direction
        W_DIR_CLR  = 4'd6,   // write-one-to-clear direction
        W_PULL_OFF = 4'd7,   // read/write pull-disable
        W_RETAIN   = 4'd8,   // read/write sleep retention
        W_FSEL_A   = 4'd9,   // read/write function select A
        W_FSEL_B   = 4'd10   // read/write function select B
    } word_e;

endpackage

// File: rtl/gpio_strobe_reg.sv
// Module: a bit vector changed only through set and clear strobes.
// Assumes the strobes are already decoded and zero when idle.
// A bit that is both set and cleared in one cycle ends up set.
module gpio_strobe_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);

    // Purpose: apply clear then set so that set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o & ~clr_i) | set_i;
    end

    a_r2_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((q_o & $past(set_i)) == $past(set_i)));

    a_r2_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((q_o & $past(clr_i & ~set_i)) == '0));

    a_r2_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((q_o ^ $past(q_o)) & ~$past(set_i | clr_i)) == '0));

endmodule

// File: rtl/gpio_cfg_reg.sv
// Module: a plain read/write configuration vector.
// Assumes wr_i is a one-cycle decoded write enable.
module gpio_cfg_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] q_o
);

    // Purpose: load the whole word on a write and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (wr_i) q_o <= wdata_i;
    end

    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && wr_i |=> q_o == $past(wdata_i));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !wr_i |=> $stable(q_o));

endmodule

// File: rtl/gpio_in_sync.sv
// Module: a two-flop synchronizer for the asynchronous pad inputs.
// Assumes each pin is sampled on its own; bus-wide coherence is not needed.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Purpose: shift the pad levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: per-pin pad control. It merges the stored configuration with the
// sleep request and drives the signals for the external pad mux.
// Assumes all inputs are registered configuration or a stable sleep level.
module gpio_pad_ctrl #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_i,
    input  logic [PINS-1:0] dout_i,
    input  logic [PINS-1:0] dir_i,
    input  logic [PINS-1:0] pull_off_i,
    input  logic [PINS-1:0] retain_i,
    input  logic [PINS-1:0] fsel_a_i,
    input  logic [PINS-1:0] fsel_b_i,
    output logic [PINS-1:0] oe_o,
    output logic [PINS-1:0] out_o,
    output logic [PINS-1:0] pull_en_o,
    output logic [PINS-1:0] pull_up_o,
    output logic [PINS-1:0] func_a_o,
    output logic [PINS-1:0] func_b_o
);

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic sleep_in;

        // Purpose: decide each pin's pad drive, with the sleep override.
        always_comb begin
            sleep_in     = sleep_i & ~retain_i[p];
            oe_o[p]      = dir_i[p] & ~sleep_in;
            out_o[p]     = dout_i[p];
            pull_en_o[p] = sleep_in | (~pull_off_i[p] & ~dir_i[p]);
            pull_up_o[p] = dout_i[p];
            func_a_o[p]  = fsel_a_i[p];
            func_b_o[p]  = fsel_b_i[p];
        end
    end

    a_r5_no_pull_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o & pull_en_o) == '0);

    a_r7_sleep_releases: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> ((oe_o & ~retain_i) == '0) && ((pull_en_o | retain_i) == '1));

endmodule

// File: rtl/gpio_bank.sv
// Module: top of the GPIO pin control register bank. It decodes the
// register bus into strobes and loads, holds the per-pin state and drives
// the pad control signals.
// Assumes a single bus master. A write takes effect at the clock edge on
// which bus_en and bus_we are high. Reads return combinationally.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS       = 32,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic              sleep_req,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_pull_en,
    output logic [PINS-1:0]   pin_pull_up,
    output logic [PINS-1:0]   pin_func_a,
    output logic [PINS-1:0]   pin_func_b
);

    logic            wr;
    logic [PINS-1:0] dout_set, dout_clr, dir_set, dir_clr;
    logic            wr_pull_off, wr_retain, wr_fsel_a, wr_fsel_b;
    logic [PINS-1:0] dout_q, dir_q, pull_off_q, retain_q, fsel_a_q, fsel_b_q;
    logic [PINS-1:0] pad_sync;

    // Purpose: turn a bus write into per-register strobes and load enables.
    always_comb begin
        wr          = bus_en & bus_we;
        dout_set    = (wr && bus_addr == W_DOUT_SET) ? bus_wdata : '0;
        dout_clr    = (wr && bus_addr == W_DOUT_CLR) ? bus_wdata : '0;
        dir_set     = (wr && bus_addr == W_DIR_SET)  ? bus_wdata : '0;
        dir_clr     = (wr && bus_addr == W_DIR_CLR)  ? bus_wdata : '0;
        wr_pull_off = wr && bus_addr == W_PULL_OFF;
        wr_retain   = wr && bus_addr == W_RETAIN;
        wr_fsel_a   = wr && bus_addr == W_FSEL_A;
        wr_fsel_b   = wr && bus_addr == W_FSEL_B;
    end

    gpio_strobe_reg #(.WIDTH(PINS)) u_dout (
        .clk(clk), .rst_n(rst_n), .set_i(dout_set), .clr_i(dout_clr), .q_o(dout_q));

    gpio_strobe_reg #(.WIDTH(PINS)) u_dir (
        .clk(clk), .rst_n(rst_n), .set_i(dir_set), .clr_i(dir_clr), .q_o(dir_q));

    gpio_cfg_reg #(.WIDTH(PINS)) u_pull_off (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_pull_off), .wdata_i(bus_wdata), .q_o(pull_off_q));

    gpio_cfg_reg #(.WIDTH(PINS)) u_retain (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_retain), .wdata_i(bus_wdata), .q_o(retain_q));

    gpio_cfg_reg #(.WIDTH(PINS)) u_fsel_a (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_fsel_a), .wdata_i(bus_wdata), .q_o(fsel_a_q));

    gpio_cfg_reg #(.WIDTH(PINS)) u_fsel_b (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_fsel_b), .wdata_i(bus_wdata), .q_o(fsel_b_q));

    gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(pad_sync));

    gpio_pad_ctrl #(.PINS(PINS)) u_pads (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_req),
        .dout_i(dout_q), .dir_i(dir_q), .pull_off_i(pull_off_q), .retain_i(retain_q),
        .fsel_a_i(fsel_a_q), .fsel_b_i(fsel_b_q),
        .oe_o(pin_oe), .out_o(pin_out), .pull_en_o(pin_pull_en), .pull_up_o(pin_pull_up),
        .func_a_o(pin_func_a), .func_b_o(pin_func_b));

    // Purpose: select the read word; write-only and unmapped words return 0.
    always_comb begin
        case (bus_addr)
            W_PAD_LVL:  bus_rdata = pad_sync;
            W_DOUT:     bus_rdata = dout_q;
            W_DIR:      bus_rdata = dir_q;
            W_PULL_OFF: bus_rdata = pull_off_q;
            W_RETAIN:   bus_rdata = retain_q;
            W_FSEL_A:   bus_rdata = fsel_a_q;
            W_FSEL_B:   bus_rdata = fsel_b_q;
            default:    bus_rdata = '0;
        endcase
    end

    a_r8_two_edge_sync: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) |=> pad_sync == $past(pad_in, 2));

    a_r9_level_word_ro: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && bus_en && bus_we && bus_addr == W_PAD_LVL |=>
            $stable(pin_out) && $stable(pin_oe) && $stable(pin_func_a) && $stable(pin_func_b));

    a_r4_out_tracks_latch: assert property (@(posedge clk) disable iff (!rst_n)
        pin_out == pin_pull_up);

endmodule

// File: tb/gpio_bank_test.sv
// Bench: a vector table of bus accesses walked by one loop, then directed
// checks of the pad outputs, sleep, synchronizer timing and reset.
module gpio_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sleep_req = 1'b0;
    logic [31:0] pad_in = '0;
    logic [31:0] pin_oe, pin_out, pin_pull_en, pin_pull_up, pin_func_a, pin_func_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sleep_req(sleep_req), .pad_in(pad_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pull_en(pin_pull_en),
        .pin_pull_up(pin_pull_up), .pin_func_a(pin_func_a), .pin_func_b(pin_func_b));

    // Vector: {write, word, data, requirement}; for reads the data is expected.
    localparam logic [40:0] VEC [0:17] = '{
        {1'b1, 4'd2,  32'h0000_00FF, 4'd2},   // R2 set low byte
        {1'b0, 4'd1,  32'h0000_00FF, 4'd2},
        {1'b1, 4'd3,  32'h0000_000F, 4'd2},   // R2 clear low nibble
        {1'b0, 4'd1,  32'h0000_00F0, 4'd2},
        {1'b1, 4'd5,  32'hFFFF_0000, 4'd3},   // R3 upper half outputs
        {1'b0, 4'd4,  32'hFFFF_0000, 4'd3},
        {1'b1, 4'd6,  32'h0F00_0000, 4'd3},   // R3 some back to inputs
        {1'b0, 4'd4,  32'hF0FF_0000, 4'd3},
        {1'b1, 4'd7,  32'h1234_5678, 4'd10},  // R10 pull-disable
        {1'b0, 4'd7,  32'h1234_5678, 4'd10},
        {1'b1, 4'd8,  32'hA5A5_A5A5, 4'd10},  // R10 retention
        {1'b0, 4'd8,  32'hA5A5_A5A5, 4'd10},
        {1'b1, 4'd9,  32'h0000_FFFF, 4'd6},   // R6 select A
        {1'b0, 4'd9,  32'h0000_FFFF, 4'd6},
        {1'b1, 4'd10, 32'h00FF_00FF, 4'd6},   // R6 select B
        {1'b0, 4'd10, 32'h00FF_00FF, 4'd6},
        {1'b0, 4'd2,  32'h0000_0000, 4'd9},   // R9 write-only reads 0
        {1'b0, 4'd15, 32'h0000_0000, 4'd9}    // R9 unmapped reads 0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic check_reset_state(input string tag);
        logic [31:0] rd;
        check({tag, " R1 oe"}, pin_oe, 32'h0);
        check({tag, " R1 pull_en"}, pin_pull_en, 32'hFFFF_FFFF);
        check({tag, " R1 pull_up"}, pin_pull_up, 32'h0);
        check({tag, " R1 func_a"}, pin_func_a, 32'h0);
        check({tag, " R1 func_b"}, pin_func_b, 32'h0);
        for (int w = 1; w < 11; w++) begin
            bus_read(w[3:0], rd);
            check({tag, " R1 readback"}, rd, 32'h0);
        end
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("initial");

        // Table walk.
        for (int i = 0; i < 18; i++) begin
            if (VEC[i][40]) begin
                bus_write(VEC[i][39:36], VEC[i][35:4]);
            end else begin
                bus_read(VEC[i][39:36], rd);
                check($sformatf("R%0d table entry %0d", VEC[i][3:0], i), rd, VEC[i][35:4]);
            end
        end

        // Pad outputs follow the stored state.
        check("R3 R4 oe", pin_oe, 32'hF0FF_0000);
        check("R4 out", pin_out, 32'h0000_00F0);
        check("R5 pull_en", pin_pull_en, 32'h0D00_A987);
        check("R5 pull_up", pin_pull_up, 32'h0000_00F0);
        check("R6 func_a", pin_func_a, 32'h0000_FFFF);
        check("R6 func_b", pin_func_b, 32'h00FF_00FF);
        // R6 encoding per pin: pin0 C=11, pin8 A=10, pin16 B=01, pin24 GPIO=00.
        check("R6 pin0 C", {30'h0, pin_func_a[0], pin_func_b[0]}, 32'd3);
        check("R6 pin8 A", {30'h0, pin_func_a[8], pin_func_b[8]}, 32'd2);
        check("R6 pin16 B", {30'h0, pin_func_a[16], pin_func_b[16]}, 32'd1);
        check("R6 pin24 GPIO", {30'h0, pin_func_a[24], pin_func_b[24]}, 32'd0);

        // R7 sleep override and release.
        sleep_req = 1'b1;
        #1;
        check("R7 sleep oe", pin_oe, 32'hA0A5_0000);
        check("R7 sleep pull_en", pin_pull_en, 32'h5F5A_FBDF);
        check("R7 sleep out kept", pin_out, 32'h0000_00F0);
        @(negedge clk);
        sleep_req = 1'b0;
        #1;
        check("R7 wake oe", pin_oe, 32'hF0FF_0000);
        check("R7 wake pull_en", pin_pull_en, 32'h0D00_A987);

        // R8 synchronizer: visible only after the second edge.
        @(negedge clk);
        pad_in = 32'hDEAD_BEEF;
        @(negedge clk);
        bus_read(4'd0, rd);
        check("R8 after one edge", rd, 32'h0);
        @(negedge clk);
        bus_read(4'd0, rd);
        check("R8 after two edges", rd, 32'hDEAD_BEEF);

        // R9 writes to the level word change nothing.
        bus_write(4'd0, 32'hFFFF_FFFF);
        check("R9 out unchanged", pin_out, 32'h0000_00F0);
        check("R9 oe unchanged", pin_oe, 32'hF0FF_0000);
        check("R9 func unchanged", pin_func_a, 32'h0000_FFFF);
        bus_read(4'd0, rd);
        check("R9 level word", rd, 32'hDEAD_BEEF);

        // R5 pull polarity on an input follows the latch; R2 single-bit set.
        bus_write(4'd2, 32'h0000_8000);
        check("R5 pull up follows latch", pin_pull_up, 32'h0000_80F0);
        check("R2 single set", pin_out, 32'h0000_80F0);
        bus_write(4'd3, 32'h0000_0000);
        check("R2 zero clear no effect", pin_out, 32'h0000_80F0);

        // R1 reset again clears everything.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        pad_in = '0;
        @(negedge clk);
        check_reset_state("rereset");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule